// File: doc/BRIEF.md
# Memory-to-Stream Burst Read Engine

This block copies a contiguous run of words out of memory and presents them, in address order, on a streaming output. A control input supplies a start byte address, a count of words and a one-cycle go pulse. The engine then walks the region with incrementing read bursts on an AXI4 read address and read data channel pair. Every word returned is placed in an internal FIFO, and the FIFO drains onto an AXI4-Stream style valid/ready output.

Burst sizing follows three limits. The first is the words still to fetch. The second is the largest burst allowed, which is the smaller of 256 beats and the FIFO depth. The third is the distance to the next 4 kB page edge. A burst goes out only after FIFO room for all of its beats has been set aside. Because of that reservation, the read data channel is always accepted and never stalls. A further burst may be requested while earlier beats are still in flight. A run flag stays high from the accepted go pulse until the last word has left the stream port. An error flag latches if any read response reports an error; after that no new bursts are issued, and the run ends once the outstanding beats have drained.

Top module: `memrd_stream`

## Requirements
- R1: The two low bits of the start address are treated as zero. Stream words appear in order and are the memory words at base, base+4, base+8 and so on, with base being the cleared start address.
- R2: Every read request carries ARSIZE = 2 (4-byte beats), ARBURST = 2'b01 (incrementing) and ARID = 0.
- R3: No burst has more beats than the smaller of 256 and the FIFO depth (64 by default), so ARLEN never exceeds that limit minus one.
- R4: No burst crosses a 4 kB address boundary. A burst that would cross is cut to end at the boundary. Consecutive bursts cover the region with no gaps or overlaps.
- R5: A burst is issued only when uncommitted FIFO room covers all of its beats, so the FIFO never overflows. RREADY is high whenever any requested beat has not yet arrived.
- R6: A new burst may be requested while beats of an earlier burst are still outstanding.
- R7: A read response whose RRESP bit 1 is set latches the error flag. No new burst is requested afterwards. The run still ends after the outstanding beats have arrived and the FIFO has drained. The next accepted go pulse clears the flag.
- R8: A go pulse that arrives while the engine is running is ignored.
- R9: A go pulse with a word count of zero causes no bus traffic and leaves the run flag low.
- R10: The run flag is high in the cycle after an accepted go pulse with a non-zero count. It falls once every requested word has been delivered on the stream port.
- R11: Once ARVALID is raised, it stays high with ARADDR and ARLEN unchanged until ARREADY accepts it.
- R12: After reset the run flag, error flag, ARVALID and the stream valid are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_base | input | AW | Start byte address (low two bits ignored) |
| ctl_words | input | LENW | Number of 32-bit words to move |
| ctl_go | input | 1 | Start pulse |
| run_busy | output | 1 | High while a transfer is in progress |
| run_err | output | 1 | Latched read-response error |
| m_axi_araddr | output | AW | Read burst address |
| m_axi_arlen | output | 8 | Beats minus one |
| m_axi_arsize | output | 3 | Beat size code |
| m_axi_arburst | output | 2 | Burst type |
| m_axi_arid | output | IDW | Transaction ID (constant) |
| m_axi_arvalid | output | 1 | Read address valid |
| m_axi_arready | input | 1 | Read address ready |
| m_axi_rdata | input | DW | Read data |
| m_axi_rresp | input | 2 | Read response |
| m_axi_rlast | input | 1 | Last beat of burst (not used) |
| m_axi_rvalid | input | 1 | Read data valid |
| m_axi_rready | output | 1 | Read data ready |
| st_data | output | DW | Stream data |
| st_valid | output | 1 | Stream valid |
| st_ready | input | 1 | Stream ready |

## Verification
The copy is run over several regions. A short region inside one page must give a single burst. A misaligned single-word start shows that the low address bits are cleared. A region straddling a page edge must split at the edge and overlap its two requests in flight. Long regions must split at the FIFO depth, and one of these ends exactly on a page edge, so depth and edge splits act together. Some runs stall the stream consumer or toggle ARREADY, which separates correct credit accounting and request holding from designs that only work at full rate. Directed runs inject an error response, pulse go during a run and ask for zero words, covering the stop, ignore and no-traffic paths.

// File: rtl/memrd_pkg.sv
package memrd_pkg;
  localparam logic [1:0] BURST_INCR = 2'b01;
  localparam int PAGE_BYTES = 4096;
  localparam int MAX_BEATS  = 256;

  function automatic int min_int(input int a, input int b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/memrd_burst_calc.sv
module memrd_burst_calc
  import memrd_pkg::*;
#(
  parameter int AW   = 32,
  parameter int LENW = 20,
  parameter int DW   = 32,
  parameter int CAP  = 64,
  parameter int BW   = 7
) (
  input  logic [AW-1:0]   addr,
  input  logic [LENW-1:0] remain,
  output logic [BW-1:0]   beats
);
  localparam int BYTE_SH = $clog2(DW/8);
  localparam int PW      = $clog2(PAGE_BYTES);
  localparam int WPP     = PAGE_BYTES / (DW/8);

  logic [31:0] to_edge, lim, rem32;

  always_comb begin
    to_edge = 32'(WPP) - 32'(addr[PW-1:BYTE_SH]);
    lim     = (to_edge < 32'(CAP)) ? to_edge : 32'(CAP);
    rem32   = 32'(remain);
    beats   = BW'((rem32 < lim) ? rem32 : lim);
  end
endmodule

// File: rtl/memrd_fifo.sv
module memrd_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  output logic          mem_empty
);
  localparam int PTRW = $clog2(DEPTH);

  logic [DW-1:0]   mem [DEPTH];
  logic [PTRW-1:0] wptr, rptr;
  logic [PTRW:0]   cnt;
  logic            load;

  assign load      = (cnt != '0) && (!out_valid || out_ready);
  assign mem_empty = (cnt == '0);

  // storage and registered read port, no reset so it maps to block RAM
  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= din;
    if (load) out_data <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr      <= '0;
      rptr      <= '0;
      cnt       <= '0;
      out_valid <= 1'b0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (load) rptr <= rptr + 1'b1;
      cnt <= cnt + {{PTRW{1'b0}}, push} - {{PTRW{1'b0}}, load};
      if (load)           out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
    end
  end

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    push |-> (cnt < (PTRW+1)'(DEPTH)));
endmodule

// File: rtl/memrd_stream.sv
module memrd_stream
  import memrd_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int LENW   = 20,
  parameter int IDW    = 4,
  parameter int DEPTH  = 64,
  parameter logic [IDW-1:0] ID_VAL = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   ctl_base,
  input  logic [LENW-1:0] ctl_words,
  input  logic            ctl_go,
  output logic            run_busy,
  output logic            run_err,
  output logic [AW-1:0]   m_axi_araddr,
  output logic [7:0]      m_axi_arlen,
  output logic [2:0]      m_axi_arsize,
  output logic [1:0]      m_axi_arburst,
  output logic [IDW-1:0]  m_axi_arid,
  output logic            m_axi_arvalid,
  input  logic            m_axi_arready,
  input  logic [DW-1:0]   m_axi_rdata,
  input  logic [1:0]      m_axi_rresp,
  input  logic            m_axi_rlast,
  input  logic            m_axi_rvalid,
  output logic            m_axi_rready,
  output logic [DW-1:0]   st_data,
  output logic            st_valid,
  input  logic            st_ready
);
  localparam int BYTE_SH = $clog2(DW/8);
  localparam int CAP     = min_int(MAX_BEATS, DEPTH);
  localparam int BW      = $clog2(CAP + 1);
  localparam int CW      = $clog2(DEPTH + 1);
  localparam int PW      = $clog2(PAGE_BYTES);
  localparam int WPP     = PAGE_BYTES / (DW/8);

  logic            busy_q, err_q;
  logic [AW-1:0]   addr_q;
  logic [LENW-1:0] rem_q;
  logic            arvalid_q;
  logic [AW-1:0]   araddr_q;
  logic [7:0]      arlen_q;
  logic [BW-1:0]   beats_q;
  logic [CW-1:0]   credit_q, outst_q;
  logic [BW-1:0]   beats_nx;
  logic            go_ok, issue, ar_hs, r_hs, pop, finish;
  logic            fifo_empty;
  logic            unused_ok;

  assign unused_ok = ^{m_axi_rlast, m_axi_rresp[0], ctl_base[BYTE_SH-1:0]};

  memrd_burst_calc #(
    .AW(AW), .LENW(LENW), .DW(DW), .CAP(CAP), .BW(BW)
  ) u_calc (
    .addr   (addr_q),
    .remain (rem_q),
    .beats  (beats_nx)
  );

  memrd_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (r_hs),
    .din       (m_axi_rdata),
    .out_ready (st_ready),
    .out_data  (st_data),
    .out_valid (st_valid),
    .mem_empty (fifo_empty)
  );

  assign go_ok  = ctl_go && !busy_q;
  assign ar_hs  = arvalid_q && m_axi_arready;
  assign r_hs   = m_axi_rvalid && m_axi_rready;
  assign pop    = st_valid && st_ready;
  assign issue  = busy_q && !err_q && !arvalid_q && (rem_q != '0) &&
                  (credit_q >= CW'(beats_nx));
  assign finish = busy_q && (err_q || rem_q == '0) && !arvalid_q &&
                  (outst_q == '0) && fifo_empty && !st_valid;

  // control and burst planning
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      err_q     <= 1'b0;
      addr_q    <= '0;
      rem_q     <= '0;
      arvalid_q <= 1'b0;
      araddr_q  <= '0;
      arlen_q   <= '0;
      beats_q   <= '0;
    end else begin
      if (go_ok) begin
        addr_q <= {ctl_base[AW-1:BYTE_SH], {BYTE_SH{1'b0}}};
        rem_q  <= ctl_words;
        busy_q <= (ctl_words != '0);
        err_q  <= 1'b0;
      end else begin
        if (finish) busy_q <= 1'b0;
        if (r_hs && m_axi_rresp[1]) err_q <= 1'b1;
        if (issue) begin
          arvalid_q <= 1'b1;
          araddr_q  <= addr_q;
          arlen_q   <= 8'(beats_nx - 1'b1);
          beats_q   <= beats_nx;
          addr_q    <= addr_q + AW'({beats_nx, {BYTE_SH{1'b0}}});
          rem_q     <= rem_q - LENW'(beats_nx);
        end else if (ar_hs) begin
          arvalid_q <= 1'b0;
        end
      end
    end
  end

  // FIFO room not yet promised, and beats requested but not yet returned
  always_ff @(posedge clk) begin
    if (rst) begin
      credit_q <= CW'(DEPTH);
      outst_q  <= '0;
    end else begin
      credit_q <= credit_q - (ar_hs ? CW'(beats_q) : '0) + (pop ? CW'(1) : '0);
      outst_q  <= outst_q + (ar_hs ? CW'(beats_q) : '0) - (r_hs ? CW'(1) : '0);
    end
  end

  assign run_busy      = busy_q;
  assign run_err       = err_q;
  assign m_axi_araddr  = araddr_q;
  assign m_axi_arlen   = arlen_q;
  assign m_axi_arsize  = 3'(BYTE_SH);
  assign m_axi_arburst = BURST_INCR;
  assign m_axi_arid    = ID_VAL;
  assign m_axi_arvalid = arvalid_q;
  assign m_axi_rready  = (outst_q != '0);

  p_ar_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (m_axi_arvalid && !m_axi_arready) |=>
      (m_axi_arvalid && $stable(m_axi_araddr) && $stable(m_axi_arlen)));

  p_page_r4: assert property (@(posedge clk) disable iff (rst)
    m_axi_arvalid |->
      ((32'(m_axi_araddr[PW-1:BYTE_SH]) + 32'(m_axi_arlen)) < 32'(WPP)));

  p_len_cap_r3: assert property (@(posedge clk) disable iff (rst)
    m_axi_arvalid |-> (32'(m_axi_arlen) < 32'(CAP)));

  p_align_r1: assert property (@(posedge clk) disable iff (rst)
    m_axi_arvalid |-> (m_axi_araddr[BYTE_SH-1:0] == '0));

  p_stop_on_err_r7: assert property (@(posedge clk) disable iff (rst)
    err_q |=> !$rose(m_axi_arvalid));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> (!m_axi_arvalid && !m_axi_rready));
endmodule

// File: tb/tb_memrd_stream.sv
module tb_memrd_stream;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, DW = 32, LENW = 20, IDW = 4, DEPTH = 64;
  localparam int NV = 7;
  // vector table: start address, word count, expected bursts, slow sink, stalling arready
  localparam logic [31:0] V_ADDR [NV] = '{32'h1000, 32'h1003, 32'h2FF0, 32'h4000,
                                          32'h5F00, 32'h8000, 32'h9FFC};
  localparam int V_LEN  [NV] = '{10, 1, 8, 200, 100, 130, 3};
  localparam int V_NAR  [NV] = '{1, 1, 2, 4, 2, 3, 2};
  localparam int V_SLOW [NV] = '{0, 0, 0, 0, 0, 1, 0};
  localparam int V_STAL [NV] = '{0, 0, 0, 0, 1, 0, 1};

  logic clk = 0, rst = 1;
  logic [AW-1:0] ctl_base = '0;
  logic [LENW-1:0] ctl_words = '0;
  logic ctl_go = 0;
  logic run_busy, run_err;
  logic [AW-1:0] araddr; logic [7:0] arlen; logic [2:0] arsize; logic [1:0] arburst;
  logic [IDW-1:0] arid; logic arvalid, arready;
  logic [DW-1:0] rdata; logic [1:0] rresp; logic rlast, rvalid, rready;
  logic [DW-1:0] st_data; logic st_valid, st_ready;

  memrd_stream #(.AW(AW), .DW(DW), .LENW(LENW), .IDW(IDW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .ctl_base(ctl_base), .ctl_words(ctl_words), .ctl_go(ctl_go),
    .run_busy(run_busy), .run_err(run_err),
    .m_axi_araddr(araddr), .m_axi_arlen(arlen), .m_axi_arsize(arsize),
    .m_axi_arburst(arburst), .m_axi_arid(arid), .m_axi_arvalid(arvalid),
    .m_axi_arready(arready), .m_axi_rdata(rdata), .m_axi_rresp(rresp),
    .m_axi_rlast(rlast), .m_axi_rvalid(rvalid), .m_axi_rready(rready),
    .st_data(st_data), .st_valid(st_valid), .st_ready(st_ready));

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  int slow = 0, stall = 0;
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  logic [31:0] exp_base = '0, next_ar = '0;
  int nwords = 0, word_bad = 0, ar_count = 0, ar_bad = 0, maxob = 0, rready_bad = 0;
  logic [31:0] qa [16];
  int ql [16];
  int qh = 0, qt = 0, beat = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // memory slave: word at byte address A reads as A
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      qh = 0; qt = 0; beat = 0;
      rvalid <= 1'b0; arready <= 1'b0; rdata <= '0; rresp <= '0; rlast <= 1'b0;
    end else begin
      if ((qt != qh) && !rready) rready_bad++;
      if (arvalid && arready) begin
        qa[qt[3:0]] = araddr; ql[qt[3:0]] = int'(arlen) + 1; qt++; ar_count++;
        if (int'(arlen) > DEPTH - 1) ar_bad++;
        if (int'(araddr[11:0]) + 4 * (int'(arlen) + 1) > 4096) ar_bad++;
        if (arsize != 3'd2 || arburst != 2'b01 || arid != '0) ar_bad++;
        if (araddr != next_ar) ar_bad++;
        next_ar = araddr + 32'(4 * (int'(arlen) + 1));
      end
      if (rvalid && rready) begin
        beat++;
        if (beat == ql[qh[3:0]]) begin beat = 0; qh++; end
      end
      if (qt - qh > maxob) maxob = qt - qh;
      if (qt != qh) begin
        rvalid <= 1'b1;
        rdata  <= qa[qh[3:0]] + 32'(4 * beat);
        rresp  <= (qa[qh[3:0]] + 32'(4 * beat) == err_addr) ? 2'b10 : 2'b00;
        rlast  <= (beat == ql[qh[3:0]] - 1);
      end else begin
        rvalid <= 1'b0;
      end
      arready <= (stall != 0) ? ~arready : 1'b1;
    end
  end

  // stream sink
  always @(posedge clk) begin
    if (rst) st_ready <= 1'b0;
    else begin
      if (st_valid && st_ready) begin
        if (st_data != exp_base + 32'(4 * nwords)) word_bad++;
        nwords++;
      end
      st_ready <= (slow != 0) ? (cyc % 3 == 0) : 1'b1;
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc == 150000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic kick(input logic [31:0] a, input int n);
    @(negedge clk);
    exp_base = {a[31:2], 2'b00}; next_ar = exp_base;
    nwords = 0; word_bad = 0; ar_count = 0; ar_bad = 0; maxob = 0; rready_bad = 0;
    ctl_base = a; ctl_words = LENW'(n); ctl_go = 1'b1;
    @(negedge clk);
    ctl_go = 1'b0;
  endtask

  task automatic wait_idle();
    int k = 0;
    while (run_busy && k < 5000) begin @(negedge clk); k++; end
    chk(!run_busy, "R10 run ends", run_busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!run_busy, "R12 busy after reset", run_busy, 0);
    chk(!run_err, "R12 err after reset", run_err, 0);
    chk(!arvalid, "R12 arvalid after reset", arvalid, 0);
    chk(!st_valid, "R12 st_valid after reset", st_valid, 0);
    rst = 0;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      slow = V_SLOW[i]; stall = V_STAL[i];
      kick(V_ADDR[i], V_LEN[i]);
      chk(run_busy, "R10 busy after go", run_busy, 1);
      wait_idle();
      chk(nwords == V_LEN[i], "R1 word count", nwords, V_LEN[i]);
      chk(word_bad == 0, "R1 word values", word_bad, 0);
      chk(ar_count == V_NAR[i], "R3/R4 burst count", ar_count, V_NAR[i]);
      chk(ar_bad == 0, "R2/R3/R4 request fields", ar_bad, 0);
      chk(rready_bad == 0, "R5 rready while outstanding", rready_bad, 0);
      chk(!run_err, "R7 no error", run_err, 0);
      if (i == 2) chk(maxob >= 2, "R6 overlapping bursts", maxob, 2);
    end
    slow = 0; stall = 0;

    // error response stops further requests
    err_addr = 32'h4040;
    kick(32'h4000, 200);
    wait_idle();
    chk(run_err, "R7 error latched", run_err, 1);
    chk(ar_count == 1, "R7 no request after error", ar_count, 1);
    chk(nwords == 64, "R7 outstanding drained", nwords, 64);
    err_addr = 32'hFFFF_FFFF;
    kick(32'h1000, 2);
    chk(!run_err, "R7 error cleared by go", run_err, 0);
    wait_idle();

    // go during a run is ignored
    kick(32'hA000, 100);
    repeat (5) @(negedge clk);
    ctl_base = 32'hC000; ctl_words = 7; ctl_go = 1'b1;
    @(negedge clk);
    ctl_go = 1'b0;
    wait_idle();
    chk(nwords == 100, "R8 go while busy ignored count", nwords, 100);
    chk(word_bad == 0, "R8 go while busy ignored data", word_bad, 0);

    // zero words
    kick(32'h1000, 0);
    chk(!run_busy, "R9 zero length busy", run_busy, 0);
    repeat (10) @(negedge clk);
    chk(ar_count == 0, "R9 zero length no request", ar_count, 0);
    chk(nwords == 0, "R9 zero length no data", nwords, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule